// File: doc/BRIEF.md
# Lock-Synchronized Ping-Pong Buffer

This block is a two-bank data memory that carries fixed-size blocks from one producer to one consumer. Each bank has its own lock. A lock holds one state bit that says whether the bank is ready to be written or ready to be read. Each agent works on one bank at a time, which its bank pointer names. To start a block, the agent requests the lock of that bank. The grant comes only when the lock is in the state that the agent needs. The agent then accesses the bank, and it ends the block by asserting done. Done releases the lock, moves the lock into the opposite state and advances the agent's pointer to the other bank, where the agent requests again.

The two agents never exchange a shared swap signal. The producer fills one bank while the consumer drains the other, and each side stalls on its own when the bank it wants is not yet in the state it needs. A system that overlaps external transfers with computation instantiates this block twice: one pair faces the stream side and the other faces the compute side.

Top module: `pp_lock_buf`

## Requirements
- R1: After reset, both locks are writable (state 0), no grant is high, both bank pointers are 0, both error flags are low, `bank_empty_o` is 2'b11 and `bank_full_o` is 2'b00. Memory contents reset to 0.
- R2: Suppose the producer's lock is not held, `p_acq_i` is high and the lock of its current bank is writable. Then `p_gnt_o` is high from the next cycle and stays high until a done is accepted.
- R3: A producer done while `p_gnt_o` is high takes effect on the next cycle. The bank becomes readable (`bank_full_o[b]`=1), `p_gnt_o` falls and `p_bank_o` moves to the other bank.
- R4: The consumer mirrors the producer. It is granted only on a readable lock. Its accepted done makes the bank writable (`bank_empty_o[b]`=1), drops `c_gnt_o` and moves `c_bank_o` to the other bank.
- R5: An acquire on a lock in the wrong state leaves the grant low. The request is retried on every cycle and is granted on the cycle after the lock first shows the needed state.
- R6: Suppose one agent releases a lock in the same cycle that the other agent requests it. The release applies first. The request fails in that cycle and the grant rises one cycle later, two cycles after the shared cycle.
- R7: A write or read issued without the grant is ignored. Memory is unchanged, and a read returns no `c_rvalid_o`. The agent's sticky error flag (`p_err_o` or `c_err_o`) is set and stays set until reset.
- R8: A done asserted while the agent does not hold its lock is ignored. Lock states and bank pointers are unchanged.
- R9: A granted consumer read at word address A returns the word the producer last wrote at A in that bank. `c_data_o` and `c_rvalid_o` are valid on the cycle after the read.
- R10: The producer may hold one bank while the consumer holds the other, and both can access their banks in the same cycle. The two agents never hold the same bank together.
- R11: `bank_empty_o[b]` is high when lock b is writable and not held by the producer. `bank_full_o[b]` is high when lock b is readable and not held by the consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| p_acq_i | input | 1 | Producer lock request for its current bank |
| p_done_i | input | 1 | Producer block complete, releases lock |
| p_wr_i | input | 1 | Producer write strobe |
| p_addr_i | input | AW | Producer word address within bank |
| p_data_i | input | DATA_W | Producer write data |
| p_gnt_o | output | 1 | Producer holds lock of its current bank |
| p_bank_o | output | 1 | Producer's current bank |
| p_err_o | output | 1 | Sticky: producer accessed without lock |
| c_acq_i | input | 1 | Consumer lock request for its current bank |
| c_done_i | input | 1 | Consumer block complete, releases lock |
| c_rd_i | input | 1 | Consumer read strobe |
| c_addr_i | input | AW | Consumer word address within bank |
| c_data_o | output | DATA_W | Read data, one cycle after read |
| c_rvalid_o | output | 1 | Read data valid |
| c_gnt_o | output | 1 | Consumer holds lock of its current bank |
| c_bank_o | output | 1 | Consumer's current bank |
| c_err_o | output | 1 | Sticky: consumer accessed without lock |
| bank_empty_o | output | 2 | Per bank: writable and not held by producer |
| bank_full_o | output | 2 | Per bank: readable and not held by consumer |

## Verification
Blocks are sent as arithmetic sequences. Each table row gives a different base and stride, so a word from the wrong bank, the wrong address or an earlier block shows up as a data mismatch. The bench first fills one bank alone. It then runs pipelined rounds in which the producer writes one bank while the consumer reads the other on the same cycles, which separates true concurrency from a design that serializes or swaps banks globally. Directed sequences follow. One holds a consumer request against an empty bank, which checks the retry behaviour. One collides a release with an acquire on the same lock, which checks the release-first ordering. Further sequences issue a done, a write and a read without the lock held. A later read of a word the stray write would have hit shows whether that write was really dropped.

// File: rtl/pp_lock_pkg.sv
package pp_lock_pkg;
  typedef enum logic {LK_WRITABLE = 1'b0, LK_READABLE = 1'b1} lock_state_e;
  typedef enum logic {ROLE_PROD = 1'b0, ROLE_CONS = 1'b1} role_e;
endpackage

// File: rtl/pp_lock_cell.sv
module pp_lock_cell
  import pp_lock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prod_rel_i,
  input  logic cons_rel_i,
  output logic state_o
);
  lock_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_q <= LK_WRITABLE;
    else if (prod_rel_i) state_q <= LK_READABLE;
    else if (cons_rel_i) state_q <= LK_WRITABLE;
  end

  assign state_o = state_q;

  // R10: the two owners are exclusive, so never release the same lock together
  a_r10_single_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prod_rel_i && cons_rel_i));
  a_r3_prod_rel_readable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_rel_i |=> state_o == LK_READABLE);
  a_r4_cons_rel_writable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons_rel_i |=> state_o == LK_WRITABLE);
endmodule

// File: rtl/pp_agent.sv
module pp_agent
  import pp_lock_pkg::*;
#(
  parameter role_e ROLE = ROLE_PROD
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acq_i,
  input  logic       done_i,
  input  logic       acc_i,
  input  logic [1:0] lock_state_i,
  output logic       held_o,
  output logic       bank_o,
  output logic [1:0] rel_o,
  output logic       acc_ok_o,
  output logic       err_o
);
  localparam logic WANT = (ROLE == ROLE_PROD) ? 1'b0 : 1'b1;

  logic held_q, bank_q, err_q;
  logic acq_ok, rel;

  assign acq_ok = !held_q && acq_i && (lock_state_i[bank_q] == WANT);
  assign rel    = held_q && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      bank_q <= 1'b0;
    end else if (rel) begin
      held_q <= 1'b0;
      bank_q <= ~bank_q;
    end else if (acq_ok) begin
      held_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               err_q <= 1'b0;
    else if (acc_i && !held_q) err_q <= 1'b1;
  end

  assign rel_o    = {rel & bank_q, rel & ~bank_q};
  assign acc_ok_o = acc_i & held_q;
  assign held_o   = held_q;
  assign bank_o   = bank_q;
  assign err_o    = err_q;

  a_r2_held_matches_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |-> lock_state_i[bank_q] == WANT);
  a_r3_release_moves_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel |=> (!held_q && bank_q != $past(bank_q)));
  a_r5_grant_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> $past(acq_i));
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r8_done_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !held_q) |=> $stable(bank_q));
endmodule

// File: rtl/pp_bank_mem.sv
module pp_bank_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wbank_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic              rbank_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i && (wbank_i == b[0])) begin
        mem_q[waddr_i] <= wdata_i;
      end
    end

    assign bank_rd[b] = mem_q[raddr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) rdata_o <= bank_rd[rbank_i];
    end
  end
endmodule

// File: rtl/pp_lock_buf.sv
module pp_lock_buf
  import pp_lock_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              p_acq_i,
  input  logic              p_done_i,
  input  logic              p_wr_i,
  input  logic [AW-1:0]     p_addr_i,
  input  logic [DATA_W-1:0] p_data_i,
  output logic              p_gnt_o,
  output logic              p_bank_o,
  output logic              p_err_o,
  input  logic              c_acq_i,
  input  logic              c_done_i,
  input  logic              c_rd_i,
  input  logic [AW-1:0]     c_addr_i,
  output logic [DATA_W-1:0] c_data_o,
  output logic              c_rvalid_o,
  output logic              c_gnt_o,
  output logic              c_bank_o,
  output logic              c_err_o,
  output logic [1:0]        bank_empty_o,
  output logic [1:0]        bank_full_o
);
  logic [1:0] lk_state;
  logic [1:0] p_rel, c_rel;
  logic       p_held, c_held, p_bank, c_bank;
  logic       p_wr_ok, c_rd_ok;

  pp_agent #(.ROLE(ROLE_PROD)) u_prod (
    .clk_i, .rst_ni,
    .acq_i(p_acq_i), .done_i(p_done_i), .acc_i(p_wr_i),
    .lock_state_i(lk_state),
    .held_o(p_held), .bank_o(p_bank), .rel_o(p_rel),
    .acc_ok_o(p_wr_ok), .err_o(p_err_o)
  );

  pp_agent #(.ROLE(ROLE_CONS)) u_cons (
    .clk_i, .rst_ni,
    .acq_i(c_acq_i), .done_i(c_done_i), .acc_i(c_rd_i),
    .lock_state_i(lk_state),
    .held_o(c_held), .bank_o(c_bank), .rel_o(c_rel),
    .acc_ok_o(c_rd_ok), .err_o(c_err_o)
  );

  for (genvar b = 0; b < 2; b++) begin : g_lock
    pp_lock_cell u_cell (
      .clk_i, .rst_ni,
      .prod_rel_i(p_rel[b]),
      .cons_rel_i(c_rel[b]),
      .state_o(lk_state[b])
    );
    assign bank_empty_o[b] = (lk_state[b] == LK_WRITABLE) && !(p_held && (p_bank == b[0]));
    assign bank_full_o[b]  = (lk_state[b] == LK_READABLE) && !(c_held && (c_bank == b[0]));
  end

  pp_bank_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni,
    .we_i(p_wr_ok), .wbank_i(p_bank), .waddr_i(p_addr_i), .wdata_i(p_data_i),
    .re_i(c_rd_ok), .rbank_i(c_bank), .raddr_i(c_addr_i),
    .rdata_o(c_data_o), .rvalid_o(c_rvalid_o)
  );

  assign p_gnt_o  = p_held;
  assign c_gnt_o  = c_held;
  assign p_bank_o = p_bank;
  assign c_bank_o = c_bank;

  a_r10_exclusive_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(p_held && c_held && (p_bank == c_bank)));
  a_r9_read_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_rd_ok |=> c_rvalid_o);
  a_r7_no_read_unheld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rd_i && !c_gnt_o) |=> !c_rvalid_o);
  a_r11_status_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_empty_o & bank_full_o) == 2'b00);
endmodule

// File: tb/tb_pp_lock_buf.sv
module tb_pp_lock_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int NV = 4;
  // {base, stride} per block
  localparam logic [31:0] VEC [NV] = '{32'h1000_0001, 32'h2200_0011, 32'hA5A5_0102, 32'hFFF0_0003};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic p_acq_i = 0, p_done_i = 0, p_wr_i = 0;
  logic [AW-1:0] p_addr_i = '0;
  logic [DW-1:0] p_data_i = '0;
  logic c_acq_i = 0, c_done_i = 0, c_rd_i = 0;
  logic [AW-1:0] c_addr_i = '0;
  logic p_gnt_o, p_bank_o, p_err_o, c_rvalid_o, c_gnt_o, c_bank_o, c_err_o;
  logic [DW-1:0] c_data_o;
  logic [1:0] bank_empty_o, bank_full_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pp_lock_buf #(.DATA_W(DW), .DEPTH(DEPTH)) dut (.*);

  function automatic logic [DW-1:0] dat(int k, int i);
    return DW'(VEC[k][31:16] + VEC[k][15:0] * i);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk(p_gnt_o == 0 && c_gnt_o == 0, "R1 grants", {p_gnt_o, c_gnt_o}, 0);
    chk(p_bank_o == 0 && c_bank_o == 0, "R1 pointers", {p_bank_o, c_bank_o}, 0);
    chk(bank_empty_o == 2'b11 && bank_full_o == 2'b00, "R1 status", {bank_empty_o, bank_full_o}, 4'b1100);
    chk(p_err_o == 0 && c_err_o == 0, "R1 errors", {p_err_o, c_err_o}, 0);

    // R8 done without lock ignored
    p_done_i = 1; c_done_i = 1; tick(); p_done_i = 0; c_done_i = 0;
    chk(p_bank_o == 0 && c_bank_o == 0, "R8 pointers", {p_bank_o, c_bank_o}, 0);
    chk(bank_empty_o == 2'b11 && bank_full_o == 2'b00, "R8 status", {bank_empty_o, bank_full_o}, 4'b1100);

    // block 0 alone into bank 0
    p_acq_i = 1; tick(); p_acq_i = 0;
    chk(p_gnt_o == 1, "R2 grant", p_gnt_o, 1);
    chk(bank_empty_o == 2'b10, "R11 empty while held", bank_empty_o, 2'b10);
    for (int i = 0; i < DEPTH; i++) begin
      p_wr_i = 1; p_addr_i = AW'(i); p_data_i = dat(0, i); tick();
      chk(p_gnt_o == 1, "R2 grant held", p_gnt_o, 1);
    end
    p_wr_i = 0; p_done_i = 1; tick(); p_done_i = 0;
    chk(p_gnt_o == 0 && p_bank_o == 1, "R3 release", {p_gnt_o, p_bank_o}, 2'b01);
    chk(bank_full_o == 2'b01, "R3 full", bank_full_o, 2'b01);

    // pipelined rounds: produce k while consuming k-1
    for (int k = 1; k < NV; k++) begin
      p_acq_i = 1; c_acq_i = 1; tick(); p_acq_i = 0; c_acq_i = 0;
      chk(p_gnt_o == 1 && c_gnt_o == 1, "R10 both granted", {p_gnt_o, c_gnt_o}, 2'b11);
      chk(p_bank_o != c_bank_o, "R10 distinct banks", {p_bank_o, c_bank_o}, k % 2 == 1 ? 2'b10 : 2'b01);
      for (int i = 0; i < DEPTH; i++) begin
        p_wr_i = 1; p_addr_i = AW'(i); p_data_i = dat(k, i);
        c_rd_i = 1; c_addr_i = AW'(DEPTH - 1 - i);
        tick();
        chk(c_rvalid_o == 1 && c_data_o == dat(k - 1, DEPTH - 1 - i), "R9 data",
            c_data_o, dat(k - 1, DEPTH - 1 - i));
      end
      p_wr_i = 0; c_rd_i = 0; p_done_i = 1; c_done_i = 1; tick(); p_done_i = 0; c_done_i = 0;
      chk(c_rvalid_o == 0, "R9 rvalid drops", c_rvalid_o, 0);
      chk(bank_full_o[k % 2] == 1 && bank_empty_o[(k + 1) % 2] == 1, "R4 status swap",
          {bank_full_o, bank_empty_o}, k);
      chk(p_bank_o == (k + 1) % 2 && c_bank_o == k % 2, "R4 pointers",
          {p_bank_o, c_bank_o}, {1'((k + 1) % 2), 1'(k % 2)});
    end

    // drain last block
    c_acq_i = 1; tick(); c_acq_i = 0;
    chk(c_gnt_o == 1, "R4 consumer grant", c_gnt_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      c_rd_i = 1; c_addr_i = AW'(i); tick();
      chk(c_data_o == dat(NV - 1, i), "R9 drain", c_data_o, dat(NV - 1, i));
    end
    c_rd_i = 0; c_done_i = 1; tick(); c_done_i = 0;
    chk(bank_empty_o == 2'b11 && c_bank_o == 0, "R4 all empty", {bank_empty_o, c_bank_o}, 3'b110);
    chk(p_err_o == 0 && c_err_o == 0, "R7 no error on legal traffic", {p_err_o, c_err_o}, 0);

    // R7 unlocked write and read
    p_wr_i = 1; p_addr_i = 0; p_data_i = 16'h0BAD; tick(); p_wr_i = 0;
    chk(p_err_o == 1, "R7 producer error", p_err_o, 1);
    c_rd_i = 1; c_addr_i = 0; tick(); c_rd_i = 0;
    chk(c_err_o == 1 && c_rvalid_o == 0, "R7 consumer error", {c_err_o, c_rvalid_o}, 2'b10);

    // R5 consumer retries on an empty bank
    c_acq_i = 1;
    for (int j = 0; j < 3; j++) begin
      tick();
      chk(c_gnt_o == 0, "R5 no grant on empty", c_gnt_o, 0);
    end
    p_acq_i = 1; tick(); p_acq_i = 0;
    chk(p_gnt_o == 1 && c_gnt_o == 0, "R5 producer first", {p_gnt_o, c_gnt_o}, 2'b10);
    for (int i = 1; i < DEPTH; i++) begin
      p_wr_i = 1; p_addr_i = AW'(i); p_data_i = 16'h7700 + 16'(i); tick();
    end
    p_wr_i = 0; p_done_i = 1; tick(); p_done_i = 0;
    chk(c_gnt_o == 0, "R5 not yet", c_gnt_o, 0);
    tick(); c_acq_i = 0;
    chk(c_gnt_o == 1, "R5 granted after retry", c_gnt_o, 1);
    c_rd_i = 1; c_addr_i = 0; tick();
    chk(c_data_o == dat(2, 0), "R7 stray write dropped", c_data_o, dat(2, 0));
    c_addr_i = 1; tick(); c_rd_i = 0;
    chk(c_data_o == 16'h7701, "R9 new word", c_data_o, 16'h7701);
    chk(p_err_o == 1 && c_err_o == 1, "R7 sticky", {p_err_o, c_err_o}, 2'b11);

    // R6 release and acquire collide on bank 0
    p_acq_i = 1; tick(); p_acq_i = 0;
    chk(p_gnt_o == 1 && p_bank_o == 1, "R6 setup bank1", {p_gnt_o, p_bank_o}, 2'b11);
    p_done_i = 1; tick(); p_done_i = 0;
    p_acq_i = 1; tick();
    chk(p_gnt_o == 0 && p_bank_o == 0, "R6 blocked by consumer", {p_gnt_o, p_bank_o}, 0);
    c_done_i = 1; tick(); c_done_i = 0;
    chk(p_gnt_o == 0 && c_gnt_o == 0 && c_bank_o == 1, "R6 release first",
        {p_gnt_o, c_gnt_o, c_bank_o}, 3'b001);
    tick(); p_acq_i = 0;
    chk(p_gnt_o == 1, "R6 grant one cycle later", p_gnt_o, 1);
    chk(bank_full_o == 2'b10, "R11 full bank1", bank_full_o, 2'b10);

    summary();
  end
endmodule